// File: doc/BRIEF.md
# Lockable Fan Limit Register Bank

The block is a small set of registers on a byte-wide register bus: an address, a write strobe, write data and a combinational read-data return. It holds a configuration register, one maximum-duty register for each PWM channel and a policy register that decides what happens during an over-temperature event. Each channel also gets a duty output. When no override is active, this output follows the duty that the fan controller requests. When an override is active, the output is replaced by a forced value.

Firmware programs the limits and then sets a lock bit in the configuration register. That bit is one-way: from then on the duty limits, the policy register and the upper configuration bits cannot be changed until the next reset. Two bits stay writable after the lock: the monitor enable and the force-full-speed control. An external over-temperature input drives each channel either to its programmed maximum or to full duty (0xFF), as the policy register selects. A read-only ready flag reports when the power-up delay has ended.

Top module: `fan_regbank_top`

## Requirements
- R1: After reset, the configuration register reads 0x01. Every maximum-duty register reads 0xFF, the policy register reads 0x00 and every duty output is 0x00.
- R2: Configuration bit 1 is the lock. Writing 1 to it sets it at that write. Later writes of 0 do not clear it; only reset clears it.
- R3: While the lock is set, writes to the maximum-duty registers, to the policy register and to configuration bits [7:4] leave their contents unchanged.
- R4: Configuration bit 0 (monitor enable) and bit 3 (force full speed) take the written value whether or not the lock is set.
- R5: Configuration bit 2 (ready) reads 0 until the 4th rising clock edge after reset is released, and 1 from then on. Bus writes never change it.
- R6: With force full speed at 0 and the over-temperature input low, each channel's duty output equals its requested duty from the previous clock edge.
- R7: With force full speed at 1 and the over-temperature input low, each channel's duty output equals that channel's maximum-duty register, from the clock edge after the override becomes active.
- R8: While the over-temperature input is high, each channel's output is its maximum-duty register if policy bit 3 is 1, and 0xFF if policy bit 3 is 0. This takes precedence over force full speed.
- R9: Channel i's maximum-duty register is at address 0x38+i, the configuration register is at 0x40 and the policy register is at 0x7D. Other addresses read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register address |
| we_i | input | 1 | Write strobe, sampled at the rising edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| overtemp_i | input | 1 | Over-temperature event, active high |
| duty_req_i | input | 8*NUM_CH | Requested duty per channel, channel 0 in the low byte |
| duty_o | output | 8*NUM_CH | Final duty per channel, registered |

## Verification
The bench uses the default build: three channels and a ready delay of 4. With three channels the decode at 0x38 to 0x3A is exercised along with the unmapped neighbours 0x30 and 0x3B. Each channel is given distinct limits and distinct requested duties, so a swapped channel or a wrong byte lane shows up as a wrong value. The short ready delay lets every cycle of the power-up window be sampled, and the over-temperature, force and lock combinations are applied both before and after the lock is set.

// File: rtl/fan_regbank_pkg.sv
package fan_regbank_pkg;
  localparam int unsigned DW = 8;
  localparam logic [7:0] MAX_BASE_ADDR = 8'h38;
  localparam logic [7:0] CFG_ADDR      = 8'h40;
  localparam logic [7:0] POLICY_ADDR   = 8'h7D;

  localparam int unsigned CFG_MON_BIT   = 0;
  localparam int unsigned CFG_LOCK_BIT  = 1;
  localparam int unsigned CFG_RDY_BIT   = 2;
  localparam int unsigned CFG_FORCE_BIT = 3;
  localparam int unsigned POL_SEL_BIT   = 3;

  localparam logic [7:0] CFG_RESET    = 8'h01;
  localparam logic [7:0] MAX_RESET    = 8'hFF;
  localparam logic [7:0] POLICY_RESET = 8'h00;
  localparam logic [7:0] FULL_DUTY    = 8'hFF;
endpackage

// File: rtl/fan_cfg_reg.sv
module fan_cfg_reg
  import fan_regbank_pkg::*;
#(
  parameter int unsigned READY_DELAY = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          lock_o,
  output logic          force_o
);
  localparam int unsigned CNT_W = $clog2(READY_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(READY_DELAY - 1);

  logic             mon_q, lock_q, rdy_q, force_q;
  logic [3:0]       gen_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_hit;

  assign wr_hit = we_i && (addr_i == CFG_ADDR);

  // unlocked bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mon_q   <= CFG_RESET[CFG_MON_BIT];
      force_q <= CFG_RESET[CFG_FORCE_BIT];
    end else if (wr_hit) begin
      mon_q   <= wdata_i[CFG_MON_BIT];
      force_q <= wdata_i[CFG_FORCE_BIT];
    end
  end

  // lockable bits; lock itself is set-only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= CFG_RESET[CFG_LOCK_BIT];
      gen_q  <= CFG_RESET[7:4];
    end else if (wr_hit && !lock_q) begin
      lock_q <= wdata_i[CFG_LOCK_BIT];
      gen_q  <= wdata_i[7:4];
    end
  end

  // power-up delay
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == CNT_LAST) rdy_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CFG_ADDR) begin
      rdata_o[7:4]           = gen_q;
      rdata_o[CFG_FORCE_BIT] = force_q;
      rdata_o[CFG_RDY_BIT]   = rdy_q;
      rdata_o[CFG_LOCK_BIT]  = lock_q;
      rdata_o[CFG_MON_BIT]   = mon_q;
    end
  end

  assign lock_o  = lock_q;
  assign force_o = force_q;

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) lock_q |=> lock_q); // R2
  AST_GEN_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni) lock_q |=> $stable(gen_q)); // R3
  AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) rdy_q |=> rdy_q); // R5
endmodule

// File: rtl/fan_duty_limits.sv
module fan_duty_limits
  import fan_regbank_pkg::*;
#(
  parameter int unsigned NUM_CH = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [7:0]           addr_i,
  input  logic                 we_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 lock_i,
  output logic [NUM_CH*DW-1:0] max_o,
  output logic [DW-1:0]        policy_o,
  output logic [DW-1:0]        rdata_o
);
  logic [NUM_CH*DW-1:0] max_q;
  logic [DW-1:0]        policy_q;
  logic [NUM_CH*DW-1:0] rd_ch;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [7:0] CH_ADDR = 8'(MAX_BASE_ADDR + 8'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                max_q[i*DW +: DW] <= MAX_RESET;
      else if (we_i && !lock_i && addr_i == CH_ADDR) max_q[i*DW +: DW] <= wdata_i;
    end
    assign rd_ch[i*DW +: DW] = (addr_i == CH_ADDR) ? max_q[i*DW +: DW] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    policy_q <= POLICY_RESET;
    else if (we_i && !lock_i && addr_i == POLICY_ADDR) policy_q <= wdata_i;
  end

  always_comb begin
    rdata_o = (addr_i == POLICY_ADDR) ? policy_q : '0;
    for (int i = 0; i < NUM_CH; i++) rdata_o = rdata_o | rd_ch[i*DW +: DW];
  end

  assign max_o    = max_q;
  assign policy_o = policy_q;

  AST_MAX_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni) lock_i |=> $stable(max_q)); // R3
  AST_POLICY_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni) lock_i |=> $stable(policy_q)); // R3
endmodule

// File: rtl/fan_duty_override.sv
module fan_duty_override
  import fan_regbank_pkg::*;
#(
  parameter int unsigned NUM_CH = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 force_i,
  input  logic                 overtemp_i,
  input  logic                 use_max_i,
  input  logic [NUM_CH*DW-1:0] max_i,
  input  logic [NUM_CH*DW-1:0] req_i,
  output logic [NUM_CH*DW-1:0] duty_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [DW-1:0] nxt;
    logic [DW-1:0] duty_q;
    always_comb begin
      if (overtemp_i)   nxt = use_max_i ? max_i[i*DW +: DW] : FULL_DUTY;
      else if (force_i) nxt = max_i[i*DW +: DW];
      else              nxt = req_i[i*DW +: DW];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) duty_q <= '0;
      else         duty_q <= nxt;
    end
    assign duty_o[i*DW +: DW] = duty_q;

    AST_PASS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!force_i && !overtemp_i) |=> duty_q == $past(req_i[i*DW +: DW])); // R6
    AST_FORCE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (force_i && !overtemp_i) |=> duty_q == $past(max_i[i*DW +: DW])); // R7
    AST_OT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (overtemp_i && !use_max_i) |=> duty_q == FULL_DUTY); // R8
  end
endmodule

// File: rtl/fan_regbank_top.sv
module fan_regbank_top
  import fan_regbank_pkg::*;
#(
  parameter int unsigned NUM_CH      = 3,
  parameter int unsigned READY_DELAY = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [7:0]           addr_i,
  input  logic                 we_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic                 overtemp_i,
  input  logic [NUM_CH*DW-1:0] duty_req_i,
  output logic [NUM_CH*DW-1:0] duty_o
);
  logic                 lock, force_full;
  logic [DW-1:0]        rd_cfg, rd_lim, policy;
  logic [NUM_CH*DW-1:0] max_duty;

  fan_cfg_reg #(.READY_DELAY(READY_DELAY)) u_cfg (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .rdata_o(rd_cfg), .lock_o(lock), .force_o(force_full)
  );

  fan_duty_limits #(.NUM_CH(NUM_CH)) u_lim (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .lock_i(lock), .max_o(max_duty), .policy_o(policy), .rdata_o(rd_lim)
  );

  fan_duty_override #(.NUM_CH(NUM_CH)) u_ovr (
    .clk_i, .rst_ni, .force_i(force_full), .overtemp_i,
    .use_max_i(policy[POL_SEL_BIT]), .max_i(max_duty),
    .req_i(duty_req_i), .duty_o
  );

  // decodes are disjoint, unmapped addresses give zero from both
  assign rdata_o = rd_cfg | rd_lim;

  AST_DECODE_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cfg != '0) |-> (rd_lim == '0)); // R9
endmodule

// File: tb/fan_regbank_tb.sv
module fan_regbank_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;

  logic clk_i = 0, rst_ni = 0, we_i = 0, overtemp_i = 0;
  logic [7:0] addr_i = 0, wdata_i = 0, rdata_o;
  logic [NCH*8-1:0] duty_req_i = 0, duty_o;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fan_regbank_top #(.NUM_CH(NCH), .READY_DELAY(4)) dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; we_i = 1;
    @(negedge clk_i); we_i = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic rchk(string req, logic [7:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d); chk(req, {24'h0, d}, {24'h0, exp});
  endtask

  task automatic settle;
    @(negedge clk_i); @(negedge clk_i);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    rchk("R1 cfg", 8'h40, 8'h01);
    rchk("R1 max0", 8'h38, 8'hFF);
    rchk("R1 max2", 8'h3A, 8'hFF);
    rchk("R1 policy", 8'h7D, 8'h00);
    chk("R1 duty", duty_o, 0);
  endtask

  task automatic t_ready;
    logic [7:0] d;
    rst_ni = 1;
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk_i); @(negedge clk_i);
      rd(8'h40, d);
      chk("R5 ready", d[2], (k == 4));
    end
    wr(8'h40, 8'h00);
    rchk("R5 ready not writable", 8'h40, 8'h04);
  endtask

  task automatic t_map;
    wr(8'h38, 8'h80); wr(8'h39, 8'h90); wr(8'h3A, 8'hA0);
    rchk("R9 ch0", 8'h38, 8'h80);
    rchk("R9 ch1", 8'h39, 8'h90);
    rchk("R9 ch2", 8'h3A, 8'hA0);
    wr(8'h30, 8'h55); wr(8'h3B, 8'h66);
    rchk("R9 unmapped 30", 8'h30, 8'h00);
    rchk("R9 unmapped 3B", 8'h3B, 8'h00);
    rchk("R9 ch0 kept", 8'h38, 8'h80);
    rchk("R9 ch2 kept", 8'h3A, 8'hA0);
    rchk("R9 cfg kept", 8'h40, 8'h04);
  endtask

  task automatic t_normal;
    @(negedge clk_i); duty_req_i = 24'h332211;
    @(negedge clk_i); chk("R6 pass", duty_o, 24'h332211);
    duty_req_i = 24'h0A0B0C;
    @(negedge clk_i); chk("R6 pass2", duty_o, 24'h0A0B0C);
  endtask

  task automatic t_force;
    wr(8'h40, 8'h08);
    @(negedge clk_i); chk("R7 force", duty_o, 24'hA09080);
    wr(8'h40, 8'h00);
    @(negedge clk_i); chk("R7 force off", duty_o, 24'h0A0B0C);
  endtask

  task automatic t_overtemp;
    @(negedge clk_i); overtemp_i = 1;
    @(negedge clk_i); chk("R8 full", duty_o, 24'hFFFFFF);
    wr(8'h7D, 8'h08);
    @(negedge clk_i); chk("R8 max", duty_o, 24'hA09080);
    wr(8'h7D, 8'h00);
    wr(8'h40, 8'h08);
    @(negedge clk_i); chk("R8 over force", duty_o, 24'hFFFFFF);
    overtemp_i = 0;
    @(negedge clk_i); chk("R7 force after ot", duty_o, 24'hA09080);
    wr(8'h40, 8'h00);
    settle;
  endtask

  task automatic t_lock;
    wr(8'h7D, 8'h08);
    wr(8'h40, 8'h52);
    rchk("R2 lock set", 8'h40, 8'h56);
    wr(8'h38, 8'h11); wr(8'h7D, 8'h00);
    rchk("R3 max frozen", 8'h38, 8'h80);
    rchk("R3 policy frozen", 8'h7D, 8'h08);
    wr(8'h40, 8'h09);
    rchk("R4 mon force writable", 8'h40, 8'h5F);
    @(negedge clk_i); chk("R7 force locked", duty_o, 24'hA09080);
    overtemp_i = 1;
    @(negedge clk_i); chk("R3 policy still max", duty_o, 24'hA09080);
    overtemp_i = 0;
    wr(8'h40, 8'h00);
    rchk("R2 lock sticky", 8'h40, 8'h56);
    settle;
    chk("R6 after lock", duty_o, 24'h0A0B0C);
  endtask

  initial begin
    fork
      begin
        t_reset; t_ready; t_map; t_normal; t_force; t_overtemp; t_lock;
      end
      begin
        repeat (20000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog act=1 exp=0");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule